// File: doc/BRIEF.md
# Float32 to Packed 11-11-10 Colour Encoder

This block turns three single-precision colour channels into one 32-bit word of unsigned small floats. The red and green channels each become an 11-bit value with a 5-bit exponent and a 6-bit mantissa. The blue channel becomes a 10-bit value with a 5-bit exponent and a 5-bit mantissa. Every field has a biased exponent (bias 15) and an implied leading one.

The conversion always truncates. It never rounds up, and finite values that are too large clamp to the largest finite code rather than to infinity. The formats have no sign bit, so negative finite values encode as zero. Infinities and NaNs are mapped to the special codes of the small format.

The three channels are converted in parallel through a two-stage pipeline. A valid strobe travels beside the data.

Top module: `rgb_f32_pack`

## Requirements
- R1: The output word places red in bits 10:0 (exponent 10:6, mantissa 5:0), green in bits 21:11 (exponent 21:17, mantissa 16:11) and blue in bits 31:22 (exponent 31:27, mantissa 26:22).
- R2: A positive finite input in the normal range (input exponent field 113 to 142) encodes with exponent field equal to the input exponent field minus 112. Its mantissa is the top 6 (red, green) or 5 (blue) input mantissa bits, and lower bits are discarded.
- R3: A negative finite input, including negative zero, encodes as an all-zero field.
- R4: A positive finite input of magnitude 2^16 or more (input exponent field 143 to 254) encodes as exponent 11110 with an all-ones mantissa.
- R5: Positive infinity encodes as exponent 11111 with a zero mantissa. Negative infinity encodes as an all-zero field.
- R6: A NaN of either sign encodes as exponent 11111 with only the most significant mantissa bit set.
- R7: A positive value below 2^-14 encodes with a zero exponent and a mantissa of floor(value * 2^(14+M)), where M is the mantissa width of the field. Positive zero and float32 denormal inputs encode as zero.
- R8: out_vld follows in_vld by exactly two clocks, and out_word belongs to the inputs sampled with that strobe. While reset is high and on the first two edges after it, out_vld is low.
- R9: Each channel is converted independently of the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input channels valid |
| in_r | input | 32 | Red channel, single-precision bits |
| in_g | input | 32 | Green channel, single-precision bits |
| in_b | input | 32 | Blue channel, single-precision bits |
| out_vld | output | 1 | Packed word valid |
| out_word | output | 32 | Packed small-float word |

## Verification
The bench drives these corner cases through the design:
- the largest finite value of each field and values just past it;
- the smallest normal;
- the smallest denormal and the value one step below it;
- both infinities, and NaNs of both signs;
- negative and negative-zero inputs, and float32 denormals.

Each case has a typical failure mode. A design that rounded would step a truncated mantissa up to the next code. One that overflowed to infinity would emit 11111 where 11110/all-ones is due. A mishandled denormal shift would be off by a power of two near 2^-14. Dropping the sign test would turn -Inf into +Inf or a negative value into a positive one.

Mixed-class vectors, such as a NaN beside a negative value beside an overflow, expose any crosstalk between lanes. A single isolated strobe checks the exact two-cycle latency and the clean valid state after reset.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int F32_W       = 32;
    localparam int F32_EXP_W   = 8;
    localparam int F32_MANT_W  = 23;
    localparam int F32_BIAS    = 127;
    localparam int SF_EXP_W    = 5;
    localparam int SF_BIAS     = 15;
    localparam int NUM_CH      = 3;
    localparam int OUT_W       = 32;
    localparam int NORM_MIN_EXP = F32_BIAS - SF_BIAS + 1;
    localparam int SAT_MIN_EXP  = F32_BIAS + (2**SF_EXP_W - 1 - SF_BIAS);
    localparam logic [F32_EXP_W-1:0] F32_EXP_ALL = '1;

    typedef enum logic [2:0] {
        CLS_ZERO, CLS_NORM, CLS_DENORM, CLS_SAT, CLS_INF, CLS_NAN
    } sf_cls_e;

    typedef struct packed {
        sf_cls_e                 cls;
        logic [F32_EXP_W-1:0]    exp;
        logic [F32_MANT_W-1:0]   mant;
    } sf_pre_t;

    function automatic int ch_mant_w(input int ch);
        return (ch == NUM_CH - 1) ? 5 : 6;
    endfunction

    function automatic int ch_lsb(input int ch);
        int pos;
        pos = 0;
        for (int i = 0; i < ch; i++) pos += SF_EXP_W + ch_mant_w(i);
        return pos;
    endfunction
endpackage

// File: rtl/sf_classify.sv
module sf_classify
    import sfp_pkg::*;
(
    input  logic [F32_W-1:0] f_in,
    output sf_pre_t          pre
);
    logic                  sgn;
    logic [F32_EXP_W-1:0]  ex;
    logic [F32_MANT_W-1:0] mn;

    assign sgn = f_in[F32_W-1];
    assign ex  = f_in[F32_W-2 -: F32_EXP_W];
    assign mn  = f_in[F32_MANT_W-1:0];

    always_comb begin
        pre.exp  = ex;
        pre.mant = mn;
        if (ex == F32_EXP_ALL)
            pre.cls = (mn != '0) ? CLS_NAN : (sgn ? CLS_ZERO : CLS_INF);
        else if (sgn || ex == '0)
            pre.cls = CLS_ZERO;
        else if (ex >= F32_EXP_W'(SAT_MIN_EXP))
            pre.cls = CLS_SAT;
        else if (ex >= F32_EXP_W'(NORM_MIN_EXP))
            pre.cls = CLS_NORM;
        else
            pre.cls = CLS_DENORM;
    end
endmodule

// File: rtl/sf_encode.sv
module sf_encode
    import sfp_pkg::*;
#(
    parameter int MANT_W = 6
) (
    input  sf_pre_t                    pre,
    output logic [SF_EXP_W+MANT_W-1:0] code
);
    localparam int DEN_BASE = NORM_MIN_EXP + F32_MANT_W - MANT_W;
    localparam logic [SF_EXP_W-1:0] EXP_TOP = '1;
    localparam logic [SF_EXP_W-1:0] EXP_SAT = EXP_TOP - 1'b1;

    logic [F32_EXP_W:0]    den_sh;
    logic [F32_MANT_W:0]   sig;
    logic [F32_MANT_W:0]   den_val;
    logic [SF_EXP_W-1:0]   norm_exp;

    assign den_sh   = (F32_EXP_W+1)'(DEN_BASE) - {1'b0, pre.exp};
    assign sig      = {1'b1, pre.mant};
    assign den_val  = sig >> den_sh;
    assign norm_exp = SF_EXP_W'(pre.exp - F32_EXP_W'(NORM_MIN_EXP - 1));

    always_comb begin
        unique case (pre.cls)
            CLS_NORM:   code = {norm_exp, pre.mant[F32_MANT_W-1 -: MANT_W]};
            CLS_DENORM: code = {{SF_EXP_W{1'b0}}, den_val[MANT_W-1:0]};
            CLS_SAT:    code = {EXP_SAT, {MANT_W{1'b1}}};
            CLS_INF:    code = {EXP_TOP, {MANT_W{1'b0}}};
            CLS_NAN:    code = {EXP_TOP, 1'b1, {(MANT_W-1){1'b0}}};
            default:    code = '0;
        endcase
    end
endmodule

// File: rtl/sf_lane.sv
module sf_lane
    import sfp_pkg::*;
#(
    parameter int MANT_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [F32_W-1:0]           f_in,
    output logic [SF_EXP_W+MANT_W-1:0] code_q
);
    localparam int CODE_W = SF_EXP_W + MANT_W;

    sf_pre_t             pre_d, pre_q;
    logic [CODE_W-1:0]   code_d;

    sf_classify u_cls (.f_in(f_in), .pre(pre_d));
    sf_encode #(.MANT_W(MANT_W)) u_enc (.pre(pre_q), .code(code_d));

    always_ff @(posedge clk) begin
        pre_q  <= pre_d;
        code_q <= code_d;
    end

    // R3
    neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(f_in[F32_W-1], 2) && $past(f_in[F32_W-2 -: F32_EXP_W], 2) != F32_EXP_ALL)
        |-> code_q == '0);

    // R4
    sat_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(f_in[F32_W-1], 2) && $past(f_in[F32_W-2 -: F32_EXP_W], 2) != F32_EXP_ALL
         && $past(f_in[F32_W-2 -: F32_EXP_W], 2) >= F32_EXP_W'(SAT_MIN_EXP))
        |-> code_q == {{(SF_EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}});

    // R5
    pos_inf_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(f_in, 2) == {1'b0, F32_EXP_ALL, {F32_MANT_W{1'b0}}})
        |-> code_q == {{SF_EXP_W{1'b1}}, {MANT_W{1'b0}}});

    // R6
    top_exp_form_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q[CODE_W-1 -: SF_EXP_W] == '1)
        |-> (code_q[MANT_W-1:0] == '0 ||
             code_q[MANT_W-1:0] == {1'b1, {(MANT_W-1){1'b0}}}));
endmodule

// File: rtl/rgb_f32_pack.sv
module rgb_f32_pack
    import sfp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_vld,
    input  logic [31:0] in_r,
    input  logic [31:0] in_g,
    input  logic [31:0] in_b,
    output logic        out_vld,
    output logic [31:0] out_word
);
    logic [F32_W-1:0] ch_in [NUM_CH];
    logic [OUT_W-1:0] packed_w;
    logic             vld_s1;

    assign ch_in[0] = in_r;
    assign ch_in[1] = in_g;
    assign ch_in[2] = in_b;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        localparam int MW  = ch_mant_w(g);
        localparam int LSB = ch_lsb(g);
        logic [SF_EXP_W+MW-1:0] lane_code;
        sf_lane #(.MANT_W(MW)) u_lane (
            .clk(clk), .rst(rst), .f_in(ch_in[g]), .code_q(lane_code));
        assign packed_w[LSB +: SF_EXP_W+MW] = lane_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_s1  <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            vld_s1  <= in_vld;
            out_vld <= vld_s1;
        end
    end

    assign out_word = packed_w;

    // R8
    lat_two_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_vld) && !$past(rst)) |=> out_vld);

    // R8
    no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_vld) && !$past(rst)) |=> !out_vld);
endmodule

// File: tb/tb_rgb_f32_pack.sv
module tb_rgb_f32_pack;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] in_r = '0, in_g = '0, in_b = '0;
    logic        out_vld;
    logic [31:0] out_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    rgb_f32_pack dut (.clk(clk), .rst(rst), .in_vld(in_vld), .in_r(in_r),
                      .in_g(in_g), .in_b(in_b), .out_vld(out_vld), .out_word(out_word));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [10:0] ref_code(logic [31:0] f, int mw);
        int  ev;
        int  k;
        int  mn;
        real x;
        ev = int'(f[30:23]);
        if (ev == 255) begin
            if (f[22:0] != 0) return 11'((31 << mw) | (1 << (mw - 1)));
            return f[31] ? 11'd0 : 11'(31 << mw);
        end
        if (f[31] || ev == 0) return 11'd0;
        x = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (ev - 127));
        if (x >= 65536.0) return 11'((30 << mw) | ((1 << mw) - 1));
        if (x < 2.0 ** (-14)) return 11'($rtoi(x * (2.0 ** (14 + mw))));
        k = -14;
        while (k < 15 && x >= 2.0 ** (k + 1)) k++;
        mn = $rtoi(x / (2.0 ** k) * (2.0 ** mw)) - (1 << mw);
        return 11'(((k + 15) << mw) | mn);
    endfunction

    function automatic logic [31:0] ref_word(logic [31:0] r, logic [31:0] g, logic [31:0] b);
        logic [10:0] cb;
        cb = ref_code(b, 5);
        return {cb[9:0], ref_code(g, 6), ref_code(r, 6)};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(logic [31:0] r, logic [31:0] g, logic [31:0] b, string tag);
        @(negedge clk);
        in_vld = 1'b1; in_r = r; in_g = g; in_b = b;
        exp_q.push_back(ref_word(r, g, b));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected out_vld", 32'(out_vld), 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_word == e, t, out_word, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        // reset with in_vld held high: pipeline must stay clear (R8)
        in_vld = 1'b1;
        repeat (4) @(negedge clk);
        check(out_vld == 1'b0, "R8 reset out_vld", 32'(out_vld), 32'd0);
        rst = 1'b0; in_vld = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_vld == 1'b0, "R8 post-reset out_vld", 32'(out_vld), 32'd0);
        end

        // R8 exact latency with an isolated strobe; R2 value 1.0
        send(32'h3F800000, 32'h40000000, 32'h3F000000, "R2 R1 one/two/half");
        @(negedge clk); in_vld = 1'b0;
        check(out_vld == 1'b0, "R8 latency one clock", 32'(out_vld), 32'd0);
        @(negedge clk);
        check(out_vld == 1'b1, "R8 latency two clocks", 32'(out_vld), 32'd1);
        idle(2);

        // R1 distinct fields per lane
        send(32'h3F800000, 32'h00000000, 32'h00000000, "R1 red only");
        send(32'h00000000, 32'h3F800000, 32'h00000000, "R1 green only");
        send(32'h00000000, 32'h00000000, 32'h3F800000, "R1 blue only");
        // R2 truncation toward zero
        send(32'h3FFFFFFF, 32'h3FFFFFFF, 32'h3FFFFFFF, "R2 truncate 1.99999");
        send(32'h41234567, 32'h42FEDCBA, 32'h3E99999A, "R2 normal mix");
        // R4 largest finite, just past it, huge
        send(32'h477E0000, 32'h477E0000, 32'h477C0000, "R4 largest finite");
        send(32'h477FFF00, 32'h477FFFFF, 32'h477E0000, "R4 truncates to max");
        send(32'h47800000, 32'h4E6E6B28, 32'h7F7FFFFF, "R4 saturate");
        // R7 smallest normal, denormals, below smallest
        send(32'h38800000, 32'h38800000, 32'h38800000, "R7 smallest normal");
        send(32'h35800000, 32'h35800000, 32'h36000000, "R7 smallest denormal");
        send(32'h35000000, 32'h387FFFFF, 32'h35800000, "R7 below smallest / top denorm");
        send(32'h00000001, 32'h007FFFFF, 32'h00000000, "R7 f32 denorm and zero");
        // R3 negatives
        send(32'hBF800000, 32'h80000000, 32'hC7800000, "R3 negatives");
        // R5 infinities
        send(32'h7F800000, 32'hFF800000, 32'h7F800000, "R5 infinities");
        // R6 NaNs
        send(32'h7FC00000, 32'hFF800001, 32'h7F800001, "R6 NaNs");
        // R9 mixed classes across lanes
        send(32'hFFC00000, 32'hBF800000, 32'h477E0000, "R9 NaN/neg/max");
        send(32'h38000000, 32'h7F800000, 32'h80000001, "R9 denorm/inf/neg");
        idle(1);

        // randomised, with gaps (R2 R7 R9)
        for (int i = 0; i < 300; i++) begin
            logic [31:0] v [3];
            for (int c = 0; c < 3; c++) begin
                v[c] = $urandom;
                if ($urandom % 4 != 0) v[c][30:23] = 8'(95 + $urandom % 55);
            end
            send(v[0], v[1], v[2], "R9 random");
            if ($urandom % 5 == 0) idle(1 + $urandom % 3);
        end
        idle(6);
        check(exp_q.size() == 0, "R8 all outputs delivered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule